// File: doc/BRIEF.md
# DRAM Byte-Strobe Front End

This block is the control front end of a x16 dynamic memory device, written as synthesizable logic so that a memory controller can be tested against it in simulation or on an emulator. It samples the row strobe, the two byte-lane column strobes, the write and output-enable strobes, and a 10-bit multiplexed address on a fast system clock. From these it captures the row and the column, forms one internal column strobe from the two lane strobes, classifies each memory cycle, and drives per-lane write enables and per-lane data-bus driver enables.

The block also tells a refresh cycle apart from an access. If a column strobe is already low when the row strobe falls, the cycle refreshes a row chosen by an internal row counter, and the external address is ignored. If the row strobe then stays low long enough, the device enters self refresh and steps the counter on its own. A small behavioural array with byte-lane writes and an extended-data-out read register stands in for the storage.

Top module: `dram_strobe_front`

## Requirements
- R1: On a row-strobe fall with both column strobes high, `row_o` takes the address and the cycle code becomes RAS-only. The row then stays unchanged for the rest of that read or write cycle, whatever the address does.
- R2: `cas_act_o` is high while at least one of the two column strobes is low, and it returns low only after both are high. The first column-strobe fall in an access cycle loads `col_o` from the address.
- R3: `drv_en_o[0]` is high only while the row strobe, the low-lane column strobe and the output enable are all low and the write strobe is high, in an access cycle. `drv_en_o[1]` follows the same rule with the high-lane column strobe.
- R4: With the write strobe low in an access cycle, the array is written only in the lanes whose column strobe is low. `byte_wr_o` bit 0 is the low lane (data bits 7:0) and bit 1 is the high lane (data bits 15:8).
- R5: A column strobe that is low when the row strobe falls starts a refresh cycle. The code is 4, `row_o` takes the counter value, the address is ignored, both lane drivers stay off, and nothing is written.
- R6: The refresh row counter resets to 0, advances by one on each refresh-cycle start, and wraps from 1023 to 0.
- R7: A cycle ends only when the row strobe and the internal column strobe are both inactive. The code then returns to 0. For a read, write or RAS-only cycle, `rfsh_stb_o` pulses for one clock while `row_o` holds the row just refreshed. Refresh and self-refresh cycles give no pulse.
- R8: The read data register loads at the internal column-strobe fall of a read. It holds its value through the strobe rise until the next read fall.
- R9: In a refresh cycle with the row strobe held low for SELF_CYC further clocks, the code becomes 5 (self refresh). The counter then advances once every SELF_CYC clocks until the row strobe rises.
- R10: Cycle codes are 0 idle, 1 read, 2 write (also a read-modify-write), 3 RAS-only, 4 refresh, 5 self refresh. After reset the code, the counter, and the enable and strobe outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n_i | input | 1 | Row strobe, active low |
| lcas_n_i | input | 1 | Low-lane column strobe, active low |
| ucas_n_i | input | 1 | High-lane column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | 10 | Multiplexed row/column address |
| wdata_i | input | 16 | Write data |
| row_o | output | 10 | Captured row |
| col_o | output | 10 | Captured column |
| cas_act_o | output | 1 | Internal column strobe, active high |
| byte_wr_o | output | 2 | Per-lane write enables |
| drv_en_o | output | 2 | Per-lane data-bus driver enables |
| rdata_o | output | 16 | Extended-data-out read register |
| cyc_o | output | 3 | Cycle code |
| rfsh_cnt_o | output | 10 | Internal refresh row counter |
| rfsh_stb_o | output | 1 | One-clock pulse at the end of a cycle that refreshed `row_o` |

## Verification
Some properties are checked on every clock. Refresh and self-refresh cycles never drive a lane or write one. A lane driver is never on without the internal column strobe. The counter steps by exactly one as each refresh cycle begins, and that step loads the old count as the row. The row holds through an access, the end pulse follows only an access cycle, and the read register changes only after a read fall. The other checks need the directed scenarios. Two-strobe overlap and hand-off show how the internal strobe is merged. Lane writes are shown by reading back a partly rewritten word. The scenarios also show that the address and write data are ignored during refresh, that entry and stepping of self refresh take exactly SELF_CYC clocks, and that the counter wraps after 1024 refresh cycles.

// File: rtl/dsf_pkg.sv
`timescale 1ns/1ps
package dsf_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_READ    = 3'd1,
    CYC_WRITE   = 3'd2,
    CYC_RASONLY = 3'd3,
    CYC_CBR     = 3'd4,
    CYC_SELF    = 3'd5
  } cyc_e;
endpackage

// File: rtl/dsf_sample.sv
`timescale 1ns/1ps
// Input register stage: one sample of every strobe, plus the previous
// sample of the row strobe and the merged column strobe for edge detection.
module dsf_sample #(
  parameter int AW = 10,
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_n,
  input  logic [NB-1:0] bcas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          s_ras,
  output logic [NB-1:0] s_bcas,
  output logic          s_we,
  output logic          s_oe,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_wdata,
  output logic          cas_now,
  output logic          ras_fall,
  output logic          cas_fall
);
  logic p_ras, p_cas;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) s_bcas[g] <= 1'b1;
      else     s_bcas[g] <= bcas_n[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ras   <= 1'b1;
      s_we    <= 1'b1;
      s_oe    <= 1'b1;
      s_addr  <= '0;
      s_wdata <= '0;
      p_ras   <= 1'b1;
      p_cas   <= 1'b0;
    end else begin
      s_ras   <= ras_n;
      s_we    <= we_n;
      s_oe    <= oe_n;
      s_addr  <= addr;
      s_wdata <= wdata;
      p_ras   <= s_ras;
      p_cas   <= cas_now;
    end
  end

  // first lane strobe to fall activates, last to rise releases
  assign cas_now  = ~&s_bcas;
  assign ras_fall = ~s_ras & p_ras;
  assign cas_fall = cas_now & ~p_cas;
endmodule

// File: rtl/dsf_ctrl.sv
`timescale 1ns/1ps
// Cycle classifier, address latches, refresh counter and self-refresh timer.
module dsf_ctrl
  import dsf_pkg::*;
#(
  parameter int AW       = 10,
  parameter int NB       = 2,
  parameter int MEM_AW   = 8,
  parameter int SELF_CYC = 16,
  localparam int TW = $clog2(SELF_CYC + 1),
  localparam int HC = MEM_AW / 2,
  localparam int HR = MEM_AW - HC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_ras,
  input  logic [NB-1:0]     s_bcas,
  input  logic              s_we,
  input  logic              s_oe,
  input  logic [AW-1:0]     s_addr,
  input  logic              cas_now,
  input  logic              ras_fall,
  input  logic              cas_fall,
  output logic [AW-1:0]     row_q,
  output logic [AW-1:0]     col_q,
  output cyc_e              cyc_q,
  output logic [AW-1:0]     rcnt_q,
  output logic              stb_q,
  output logic              cas_q,
  output logic [NB-1:0]     bwr_q,
  output logic [NB-1:0]     drv_q,
  output logic [NB-1:0]     mem_we,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_idx
);
  localparam logic [TW-1:0] TMR_LAST = TW'(SELF_CYC - 1);

  logic [TW-1:0] tmr_q;
  logic [AW-1:0] col_nx;
  logic          acc;
  logic          in_access;

  assign in_access = (cyc_q == CYC_RASONLY) || (cyc_q == CYC_READ) ||
                     (cyc_q == CYC_WRITE);

  always_comb begin
    acc     = in_access && !s_ras && !ras_fall;
    col_nx  = cas_fall ? s_addr : col_q;
    mem_idx = {row_q[HR-1:0], col_nx[HC-1:0]};
    mem_re  = acc && cas_fall && s_we;
    for (int i = 0; i < NB; i++) mem_we[i] = acc && !s_bcas[i] && !s_we;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      col_q  <= '0;
      cyc_q  <= CYC_IDLE;
      rcnt_q <= '0;
      stb_q  <= 1'b0;
      cas_q  <= 1'b0;
      bwr_q  <= '0;
      drv_q  <= '0;
      tmr_q  <= '0;
    end else begin
      stb_q <= 1'b0;
      cas_q <= cas_now;
      bwr_q <= mem_we;
      for (int i = 0; i < NB; i++) drv_q[i] <= acc && !s_bcas[i] && !s_oe && s_we;

      if (s_ras && !cas_now && cyc_q != CYC_IDLE) begin
        cyc_q <= CYC_IDLE;
        stb_q <= in_access;
        tmr_q <= '0;
      end else if (ras_fall) begin
        tmr_q <= '0;
        if (cas_now) begin
          cyc_q  <= CYC_CBR;
          row_q  <= rcnt_q;
          rcnt_q <= rcnt_q + 1'b1;
        end else begin
          cyc_q <= CYC_RASONLY;
          row_q <= s_addr;
        end
      end else if (acc) begin
        if (cas_fall) begin
          col_q <= s_addr;
          cyc_q <= s_we ? CYC_READ : CYC_WRITE;
        end else if (cas_now && !s_we) begin
          cyc_q <= CYC_WRITE;
        end
      end else if (cyc_q == CYC_CBR && !s_ras) begin
        if (tmr_q == TMR_LAST) begin
          cyc_q <= CYC_SELF;
          tmr_q <= '0;
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end else if (cyc_q == CYC_SELF && !s_ras) begin
        if (tmr_q == TMR_LAST) begin
          tmr_q  <= '0;
          rcnt_q <= rcnt_q + 1'b1;
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (cyc_q inside {CYC_READ, CYC_WRITE}) && ($past(cyc_q) inside {CYC_READ, CYC_WRITE})
    |-> $stable(row_q)); // R1
  AST_DRV_NEEDS_CAS: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (|drv_q) |-> cas_q); // R3
  AST_RFSH_QUIET: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (cyc_q inside {CYC_CBR, CYC_SELF}) |-> (drv_q == '0 && bwr_q == '0)); // R5
  AST_RFSH_ROW: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (cyc_q == CYC_CBR && $past(cyc_q) != CYC_CBR) |-> row_q == $past(rcnt_q)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (cyc_q == CYC_CBR && $past(cyc_q) != CYC_CBR) |-> rcnt_q == $past(rcnt_q) + 1'b1); // R6
  AST_STB_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst || !past_ok)
    stb_q |-> (cyc_q == CYC_IDLE &&
               ($past(cyc_q) inside {CYC_READ, CYC_WRITE, CYC_RASONLY}))); // R7
endmodule

// File: rtl/dsf_mem.sv
`timescale 1ns/1ps
// Behavioural byte-lane array: one inferable RAM per lane, synchronous
// read into a register that holds between read strobes (extended data out).
module dsf_mem #(
  parameter int DW     = 16,
  parameter int MEM_AW = 8,
  localparam int NB    = DW / 8,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MEM_AW-1:0] idx,
  input  logic [NB-1:0]     we,
  input  logic              re,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] ram [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) ram[idx] <= wdata[g*8 +: 8];
    end
    always_ff @(posedge clk) begin
      if (rst)     rdata[g*8 +: 8] <= '0;
      else if (re) rdata[g*8 +: 8] <= ram[idx];
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_EDO_HOLD: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$past(re) |-> $stable(rdata)); // R8
endmodule

// File: rtl/dram_strobe_front.sv
`timescale 1ns/1ps
module dram_strobe_front
  import dsf_pkg::*;
#(
  parameter int AW       = 10,
  parameter int DW       = 16,
  parameter int MEM_AW   = 8,
  parameter int SELF_CYC = 16,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_n_i,
  input  logic          lcas_n_i,
  input  logic          ucas_n_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] row_o,
  output logic [AW-1:0] col_o,
  output logic          cas_act_o,
  output logic [NB-1:0] byte_wr_o,
  output logic [NB-1:0] drv_en_o,
  output logic [DW-1:0] rdata_o,
  output logic [2:0]    cyc_o,
  output logic [AW-1:0] rfsh_cnt_o,
  output logic          rfsh_stb_o
);
  logic          s_ras, s_we, s_oe, cas_now, ras_fall, cas_fall;
  logic [NB-1:0] s_bcas, mem_we;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  logic          mem_re;
  logic [MEM_AW-1:0] mem_idx;
  cyc_e          cyc;

  dsf_sample #(.AW(AW), .DW(DW)) u_smp (
    .clk(clk), .rst(rst), .ras_n(ras_n_i), .bcas_n({ucas_n_i, lcas_n_i}),
    .we_n(we_n_i), .oe_n(oe_n_i), .addr(addr_i), .wdata(wdata_i),
    .s_ras(s_ras), .s_bcas(s_bcas), .s_we(s_we), .s_oe(s_oe),
    .s_addr(s_addr), .s_wdata(s_wdata), .cas_now(cas_now),
    .ras_fall(ras_fall), .cas_fall(cas_fall));

  dsf_ctrl #(.AW(AW), .NB(NB), .MEM_AW(MEM_AW), .SELF_CYC(SELF_CYC)) u_ctl (
    .clk(clk), .rst(rst), .s_ras(s_ras), .s_bcas(s_bcas), .s_we(s_we),
    .s_oe(s_oe), .s_addr(s_addr), .cas_now(cas_now), .ras_fall(ras_fall),
    .cas_fall(cas_fall), .row_q(row_o), .col_q(col_o), .cyc_q(cyc),
    .rcnt_q(rfsh_cnt_o), .stb_q(rfsh_stb_o), .cas_q(cas_act_o),
    .bwr_q(byte_wr_o), .drv_q(drv_en_o), .mem_we(mem_we), .mem_re(mem_re),
    .mem_idx(mem_idx));

  dsf_mem #(.DW(DW), .MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .rst(rst), .idx(mem_idx), .we(mem_we), .re(mem_re),
    .wdata(s_wdata), .rdata(rdata_o));

  assign cyc_o = cyc;
endmodule

// File: tb/sim_dram_strobe_front.sv
`timescale 1ns/1ps
module sim_dram_strobe_front;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras = 1'b1, lcas = 1'b1, ucas = 1'b1, we = 1'b1, oe = 1'b1;
  logic [9:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [9:0]  row_o, col_o, rfsh_cnt_o;
  logic        cas_act_o, rfsh_stb_o;
  logic [1:0]  byte_wr_o, drv_en_o;
  logic [15:0] rdata_o;
  logic [2:0]  cyc_o;

  int n_chk = 0, n_fail = 0, stb_n = 0;
  logic [9:0] stb_row = '0;
  logic [9:0] exp_cnt = '0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_strobe_front u0 (
    .clk(clk), .rst(rst), .ras_n_i(ras), .lcas_n_i(lcas), .ucas_n_i(ucas),
    .we_n_i(we), .oe_n_i(oe), .addr_i(addr), .wdata_i(wdata),
    .row_o(row_o), .col_o(col_o), .cas_act_o(cas_act_o), .byte_wr_o(byte_wr_o),
    .drv_en_o(drv_en_o), .rdata_o(rdata_o), .cyc_o(cyc_o),
    .rfsh_cnt_o(rfsh_cnt_o), .rfsh_stb_o(rfsh_stb_o));

  always @(posedge clk) begin
    #2;
    if (!rst && rfsh_stb_o) begin
      stb_n++;
      stb_row = row_o;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic ras_open(logic [9:0] r);
    addr = r; ras = 1'b0; tick(3);
  endtask

  task automatic cas_do(logic [9:0] c, bit lo, bit hi, bit wr, logic [15:0] d);
    addr = c; wdata = d; we = !wr; lcas = !lo; ucas = !hi; tick(3);
  endtask

  task automatic cas_off();
    lcas = 1'b1; ucas = 1'b1; we = 1'b1; tick(3);
  endtask

  task automatic ras_close();
    ras = 1'b1; lcas = 1'b1; ucas = 1'b1; we = 1'b1; oe = 1'b1; tick(3);
  endtask

  task automatic quick_cbr();
    lcas = 1'b0; tick(1);
    ras = 1'b0; tick(3);
    ras = 1'b1; lcas = 1'b1; tick(3);
    exp_cnt = exp_cnt + 1'b1;
  endtask

  task automatic t_reset();
    chk("R10", "reset cycle code", cyc_o, 0);
    chk("R10", "reset counter", rfsh_cnt_o, 0);
    chk("R10", "reset drivers", drv_en_o, 0);
    chk("R10", "reset byte writes", byte_wr_o, 0);
    chk("R10", "reset strobe", {cas_act_o, rfsh_stb_o}, 0);
  endtask

  task automatic t_merge();
    lcas = 1'b0; tick(3);
    chk("R2", "low lane alone activates", cas_act_o, 1);
    ucas = 1'b0; tick(1); lcas = 1'b1; tick(3);
    chk("R2", "held by high lane after low rises", cas_act_o, 1);
    ucas = 1'b1; tick(3);
    chk("R2", "released after last rise", cas_act_o, 0);
    chk("R2", "no cycle without row strobe", cyc_o, 0);
  endtask

  task automatic t_write();
    int n0 = stb_n;
    ras_open(10'd5);
    chk("R1", "row captured", row_o, 5);
    chk("R10", "RAS-only code", cyc_o, 3);
    cas_do(10'd9, 1, 1, 1, 16'hA55A);
    chk("R2", "column captured", col_o, 9);
    chk("R10", "write code", cyc_o, 2);
    chk("R4", "both lanes write", byte_wr_o, 2'b11);
    cas_off();
    cas_do(10'd10, 1, 1, 1, 16'h1234);
    cas_off();
    ras_close();
    chk("R7", "one end pulse", stb_n, n0 + 1);
    chk("R7", "pulse row", stb_row, 5);
    chk("R7", "back to idle", cyc_o, 0);
  endtask

  task automatic t_byte();
    ras_open(10'd5);
    cas_do(10'd9, 0, 1, 1, 16'hC3FF);
    chk("R4", "high lane only", byte_wr_o, 2'b10);
    cas_off();
    ras_close();
  endtask

  task automatic t_read_edo();
    ras_open(10'd5);
    oe = 1'b0;
    cas_do(10'd9, 1, 1, 0, 16'h0000);
    chk("R10", "read code", cyc_o, 1);
    chk("R4", "merged word after lane write", rdata_o, 16'hC35A);
    chk("R3", "both drivers on", drv_en_o, 2'b11);
    cas_off();
    chk("R8", "data held after strobe rise", rdata_o, 16'hC35A);
    chk("R3", "drivers off after strobe rise", drv_en_o, 2'b00);
    chk("R2", "internal strobe inactive", cas_act_o, 0);
    addr = 10'd77; tick(3);
    chk("R1", "row stable during cycle", row_o, 5);
    cas_do(10'd10, 1, 0, 0, 16'h0000);
    chk("R8", "next read loads", rdata_o, 16'h1234);
    chk("R3", "low lane driver only", drv_en_o, 2'b01);
    oe = 1'b1; tick(3);
    chk("R3", "output enable high turns off", drv_en_o, 2'b00);
    cas_off();
    ras_close();
  endtask

  task automatic t_cbr();
    int n0 = stb_n;
    logic [9:0] c = exp_cnt;
    lcas = 1'b0; tick(2);
    oe = 1'b0; we = 1'b0; addr = 10'h3FF; wdata = 16'hFFFF;
    ras = 1'b0; tick(3);
    chk("R5", "refresh code", cyc_o, 4);
    chk("R5", "row from counter", row_o, c);
    chk("R6", "counter advanced", rfsh_cnt_o, c + 10'd1);
    chk("R5", "no drivers", drv_en_o, 0);
    chk("R5", "no lane write", byte_wr_o, 0);
    ras_close();
    exp_cnt = c + 10'd1;
    chk("R7", "no end pulse after refresh", stb_n, n0);
    chk("R7", "idle after refresh", cyc_o, 0);
    ras_open(10'd5);
    oe = 1'b0;
    cas_do(10'd9, 1, 1, 0, 16'h0000);
    chk("R5", "array untouched by refresh", rdata_o, 16'hC35A);
    cas_off();
    ras_close();
  endtask

  task automatic t_self();
    int n0 = stb_n;
    logic [9:0] c = exp_cnt;
    lcas = 1'b0; tick(2);
    ras = 1'b0; tick(40);
    chk("R9", "self refresh code", cyc_o, 5);
    chk("R9", "counter stepped on its own", rfsh_cnt_o, c + 10'd2);
    ras_close();
    exp_cnt = c + 10'd2;
    chk("R7", "idle after self refresh", cyc_o, 0);
    chk("R7", "no pulse after self refresh", stb_n, n0);
  endtask

  task automatic t_wrap();
    while (exp_cnt != 10'd1023) quick_cbr();
    chk("R6", "counter at top", rfsh_cnt_o, 1023);
    quick_cbr();
    chk("R6", "top row refreshed", row_o, 1023);
    chk("R6", "counter wrapped", rfsh_cnt_o, 0);
  endtask

  task automatic t_rasonly();
    int n0 = stb_n;
    ras_open(10'd12);
    chk("R1", "RAS-only row", row_o, 12);
    ras_close();
    chk("R7", "RAS-only end pulse", stb_n, n0 + 1);
    chk("R7", "RAS-only pulse row", stb_row, 12);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_merge();
    t_write();
    t_byte();
    t_read_edo();
    t_cbr();
    t_self();
    t_rasonly();
    t_wrap();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule